// File: doc/BRIEF.md
# Shared-Source Interrupt Node

This block is a single interrupt node that serves several event sources, for instance a counter wrap and an external capture. Each source owns a flag that hardware sets with a one-cycle pulse and software clears with a strobe. The OR of all flags is brought out as the node's combined request line, so software can poll for outstanding work.

A pending request is latched whenever any source raises a set pulse while the node enable is on. Capture does not look for a rising edge of the combined line: a fresh pulse on one source is latched even while another flag is still set, so a flag that stays up can never block later events. The pending request is shown to the CPU only while both the node enable and the global enable are on. It is cleared by the CPU acknowledge, by turning the node enable off, or by reset, and never by software clearing flags. For that reason a service routine can be entered again and find no flag set. Arbitration among nodes belongs to the surrounding interrupt controller.

Top module: `irq_shared_node`

## Requirements
- R1: While reset is asserted and after release, every flag is 0, `pend_o` is 0 and `irq_o` is 0.
- R2: A pulse on `src_set_i[i]` sets `flags_o[i]` (bit i belongs to source i) on the next clock. When set and clear reach the same source in the same cycle, the set wins.
- R3: A strobe on `clr_i[i]` without a set clears `flags_o[i]` on the next clock. The other flags keep their values.
- R4: `any_flag_o` is 1 exactly when at least one bit of `flags_o` is 1.
- R5: With `node_en_i` = 1, a set pulse on any source makes `pend_o` 1 on the next clock, even when another flag is already set.
- R6: A set pulse while `node_en_i` = 0 sets the flag but does not make `pend_o` 1. Turning the node enable on later does not create a pending request for that earlier event.
- R7: When `node_en_i` is 0, `irq_o` is 0 in the same cycle and `pend_o` is 0 from the next clock on.
- R8: `ack_i` without a same-cycle set pulse clears `pend_o` on the next clock and leaves every flag unchanged.
- R9: When a set pulse and `ack_i` arrive in the same cycle with the node enabled, `pend_o` is 1 after the clock.
- R10: With `glob_en_i` = 0, `irq_o` is 0, but pending requests are still captured. `irq_o` becomes 1 as soon as `glob_en_i` returns to 1.
- R11: Clearing flags by software does not clear `pend_o`, so `irq_o` can be 1 while every flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set_i | input | NUM_SRC | One-cycle set pulse per source |
| clr_i | input | NUM_SRC | Software clear strobe per source |
| node_en_i | input | 1 | Node enable |
| glob_en_i | input | 1 | Global enable |
| ack_i | input | 1 | CPU acknowledge and vector to this node |
| flags_o | output | NUM_SRC | Readable source flags |
| any_flag_o | output | 1 | OR of all flags (combined request line) |
| pend_o | output | 1 | Latched pending request |
| irq_o | output | 1 | Request presented to the CPU |

## Verification
On every cycle, the assertions check how each flag responds to set and clear. They also check how the pending bit responds to capture, acknowledge and a node disable, including a capture arriving together with an acknowledge. Some behaviour depends on sequences that no single-cycle property covers, and only the bench scenarios show it. One is that a source event seen while the node was disabled stays uncaptured after the enable returns. Another is that a request held back by the global enable appears later. The third is the re-service with no flag set, after software has cleared the flags.

// File: rtl/irq_node_pkg.sv
package irq_node_pkg;
  localparam int unsigned DEF_NUM_SRC = 2;

  typedef enum logic [1:0] {
    PEND_HOLD  = 2'd0,
    PEND_SET   = 2'd1,
    PEND_CLEAR = 2'd2
  } pend_act_e;
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flags_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic flag_q;
    logic flag_d;
    logic flag_en;

    always_comb begin
      flag_en = set_i[g] | clr_i[g];
      flag_d  = set_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    assign flags_o[g] = flag_q;

    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_o[g]);
    assert_flag_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flags_o[g]);
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_node_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               node_en_i,
  input  logic               ack_i,
  output logic               pend_o
);
  logic      cap_evt;
  logic      pend_q;
  logic      pend_d;
  logic      pend_en;
  pend_act_e act;

  always_comb begin
    cap_evt = node_en_i & (|set_i);
    if (!node_en_i)   act = PEND_CLEAR;
    else if (cap_evt) act = PEND_SET;
    else if (ack_i)   act = PEND_CLEAR;
    else              act = PEND_HOLD;
    pend_en = (act != PEND_HOLD);
    pend_d  = (act == PEND_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (node_en_i && (|set_i)) |=> pend_o);
  assert_node_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !node_en_i |=> !pend_o);
  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !(|set_i)) |=> !pend_o);
  assert_cap_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && node_en_i && (|set_i)) |=> pend_o);
endmodule

// File: rtl/irq_shared_node.sv
module irq_shared_node
  import irq_node_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               node_en_i,
  input  logic               glob_en_i,
  input  logic               ack_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic               any_flag_o,
  output logic               pend_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] flags;
  logic               pend;

  irq_src_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (src_set_i),
    .clr_i   (clr_i),
    .flags_o (flags)
  );

  irq_pend_ctrl #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (src_set_i),
    .node_en_i (node_en_i),
    .ack_i     (ack_i),
    .pend_o    (pend)
  );

  always_comb begin
    flags_o    = flags;
    any_flag_o = |flags;
    pend_o     = pend;
    irq_o      = pend & node_en_i & glob_en_i;
  end

  assert_ack_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !(|src_set_i) && !(|clr_i)) |=> $stable(flags_o));
endmodule

// File: tb/tb_irq_shared_node.sv
module tb_irq_shared_node;
  localparam int N = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_set = '0, clr = '0;
  logic node_en = 1'b1, glob_en = 1'b1, ack = 1'b0;
  logic [N-1:0] flags;
  logic any_flag, pend, irq;

  int checks = 0, fails = 0, cyc = 0;
  logic [N-1:0] m_flags = '0;
  logic m_pend = 1'b0;
  bit done = 0;

  irq_shared_node #(.NUM_SRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .src_set_i(src_set), .clr_i(clr),
    .node_en_i(node_en), .glob_en_i(glob_en), .ack_i(ack),
    .flags_o(flags), .any_flag_o(any_flag), .pend_o(pend), .irq_o(irq));

  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each clock edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_flags = '0;
      m_pend  = 1'b0;
    end else begin
      for (int i = 0; i < N; i++)
        if (src_set[i]) m_flags[i] = 1'b1;
        else if (clr[i]) m_flags[i] = 1'b0;
      if (!node_en) m_pend = 1'b0;
      else if (|src_set) m_pend = 1'b1;
      else if (ack) m_pend = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(flags == m_flags, "R2/R3 flags", int'(flags), int'(m_flags));
      chk(any_flag == (|m_flags), "R4 any_flag", int'(any_flag), int'(|m_flags));
      chk(pend == m_pend, "R5-R9 pend", int'(pend), int'(m_pend));
      chk(irq == (m_pend & node_en & glob_en), "R10 irq", int'(irq),
          int'(m_pend & node_en & glob_en));
    end
  end

  always @(posedge clk) begin
    if (cyc > 5000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic drv(input logic [N-1:0] s, input logic [N-1:0] c,
                     input logic ne, input logic ge, input logic a);
    @(posedge clk); #2;
    src_set = s; clr = c; node_en = ne; glob_en = ge; ack = a;
  endtask

  task automatic idle(input logic ne, input logic ge);
    drv('0, '0, ne, ge, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(flags == '0 && pend == 1'b0 && irq == 1'b0, "R1 reset", int'({flags, pend, irq}), 0);
    rst_n = 1'b1;
    idle(1, 1);
    drv(2'b01, '0, 1, 1, 0); idle(1, 1);
    chk(flags == 2'b01, "R2 set flag0", int'(flags), 1);
    chk(pend == 1'b1, "R5 capture", int'(pend), 1);
    drv('0, '0, 1, 1, 1); idle(1, 1);
    chk(pend == 1'b0, "R8 ack clears", int'(pend), 0);
    chk(flags == 2'b01, "R8 ack keeps flags", int'(flags), 1);
    drv(2'b10, '0, 1, 1, 0); idle(1, 1);
    chk(pend == 1'b1, "R5 capture while other flag set", int'(pend), 1);
    chk(any_flag == 1'b1, "R4 any", int'(any_flag), 1);
    drv(2'b01, '0, 1, 1, 1); idle(1, 1);
    chk(pend == 1'b1, "R9 capture with ack", int'(pend), 1);
    drv('0, 2'b01, 1, 1, 0); idle(1, 1);
    chk(flags == 2'b10, "R3 clear one source", int'(flags), 2);
    drv('0, 2'b10, 1, 1, 0); idle(1, 1);
    chk(flags == '0 && any_flag == 1'b0, "R3/R4 all clear", int'(flags), 0);
    chk(pend == 1'b1 && irq == 1'b1, "R11 dummy service", int'({pend, irq}), 3);
    drv('0, '0, 1, 1, 1); idle(1, 1);
    drv(2'b01, 2'b01, 1, 1, 0); idle(1, 1);
    chk(flags == 2'b01, "R2 set beats clear", int'(flags), 1);
    drv('0, '0, 1, 1, 1); idle(0, 1);
    drv(2'b10, '0, 0, 1, 0); idle(0, 1);
    chk(flags == 2'b11, "R6 flag set while disabled", int'(flags), 3);
    chk(pend == 1'b0, "R6 no capture while disabled", int'(pend), 0);
    idle(1, 1); idle(1, 1);
    chk(pend == 1'b0 && irq == 1'b0, "R6 no late capture", int'({pend, irq}), 0);
    drv(2'b01, '0, 1, 0, 0); idle(1, 0);
    chk(pend == 1'b1 && irq == 1'b0, "R10 held by global", int'({pend, irq}), 2);
    idle(1, 1); #1;
    chk(irq == 1'b1, "R10 presented on global", int'(irq), 1);
    idle(0, 1); #1;
    chk(irq == 1'b0, "R7 irq drops at once", int'(irq), 0);
    idle(1, 1);
    chk(pend == 1'b0, "R7 pend discarded", int'(pend), 0);
    // mixed traffic compared against the reference every cycle
    for (int k = 0; k < 200; k++)
      drv(2'(k * 7 % 4), 2'(k * 5 % 4), (k % 9) != 0, (k % 6) != 0, (k % 3) == 0);
    idle(1, 1); idle(1, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule